// File: doc/BRIEF.md
# Impedance Measurement Quality Gate

This block sits behind a synchronous I/Q demodulator in a bio-impedance front end and decides whether a measurement may be published. Each burst gives it a magnitude word, a phase word and three status inputs: electrode open, contact fault and ADC saturation. After a start request it raises its measurement request and waits out a programmable settling time while injection stabilizes. It then gathers a group of consecutive bursts and gives one of three verdicts: accept, retry or reject.

An accepted group publishes the mean magnitude and mean phase of its bursts. A failed group either schedules another attempt after a programmable backoff, during which the measurement request is dropped and the retry count goes up, or gives up with a reason code once the retry budget is used. Group size, settling time, backoff, both spread tolerances, the magnitude range ceiling and the retry limit are all configuration inputs.

Top module: `imp_quality_gate`

## Requirements
- R1: While reset is held and right after it, measReq, verdictValid, verdict, reasonCode, retryCnt, magOut, phaseOut and qualFlags are all zero.
- R2: A start in idle raises measReq and loads a settle timer with cfgSettle. Bursts are counted only after cfgSettle+1 cycles in the settle state, and bursts during settling are ignored.
- R3: When 2^cfgLog2N consecutive fault-free bursts have max-minus-min spreads within tolerance on both channels, the verdict is accept (verdict=1) with reasonCode 0 and qualFlags 0. magOut and phaseOut become the sums shifted right by cfgLog2N.
- R4: A burst with elecOpen or contactFault ends the group at once without accepting. qualFlags bit0 = electrode open, bit1 = contact fault, reasonCode 1 (contact) on retry. magOut and phaseOut keep their old values.
- R5: A phase spread above cfgPhaseTol fails the group even with a stable magnitude: qualFlags bit4 is set and reasonCode is 2.
- R6: A magnitude spread above cfgMagTol sets qualFlags bit5 and gives reasonCode 3. When both spreads fail, both bits are set and the phase reason (2) wins.
- R7: adcSat sets qualFlags bit2. A magnitude above cfgMagMax sets the separate bit3. Either one fails the group with reasonCode 4.
- R8: A failure with retries left gives verdict retry (2) and increments retryCnt. measReq stays low for cfgBackoff+1 cycles, then a new settle period begins.
- R9: A failure when retryCnt equals cfgMaxRetry gives verdict reject (3) with reasonCode 5 (retries exhausted). retryCnt is not changed and the gate returns to idle.
- R10: verdictValid is a single-cycle pulse. Bursts in idle and start pulses while busy have no effect.
- R11: A spread exactly equal to its tolerance passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement sequence (idle only) |
| cfgSettle | input | 16 | Settling cycles after injection starts |
| cfgBackoff | input | 16 | Backoff cycles between attempts |
| cfgLog2N | input | 2 | log2 of bursts per group |
| cfgMaxRetry | input | 4 | Retries allowed before reject |
| cfgMagTol | input | 16 | Maximum magnitude spread |
| cfgPhaseTol | input | 16 | Maximum phase spread |
| cfgMagMax | input | 16 | Magnitude range ceiling |
| burstValid | input | 1 | Burst word strobe |
| burstMag | input | 16 | Burst magnitude |
| burstPhase | input | 16 | Burst phase |
| elecOpen | input | 1 | Electrode open status |
| contactFault | input | 1 | Poor contact status |
| adcSat | input | 1 | ADC saturation status |
| measReq | output | 1 | Injection/measurement request |
| verdictValid | output | 1 | Verdict strobe |
| verdict | output | 2 | 0 none, 1 accept, 2 retry, 3 reject |
| reasonCode | output | 3 | Failure reason |
| retryCnt | output | 4 | Retries taken in this sequence |
| magOut | output | 16 | Published mean magnitude |
| phaseOut | output | 16 | Published mean phase |
| qualFlags | output | 6 | Quality flags of the last verdict |

## Verification
On every cycle, the assertions check that:
- the verdict strobe lasts one cycle;
- an accept never carries contact, phase-spread or other flags;
- every retry advances the count by one and drops the measurement request;
- every reject carries the exhausted reason at the retry limit;
- the published values never move on a non-accept verdict.

Only the bench scenarios can show the remaining behaviour: the timing of settling and backoff, the means and the equal-to-tolerance boundary, the priority between reasons, and that bursts or starts arriving at the wrong time are ignored. The bench also checks these against a queue-based model on every clock.

// File: rtl/imp_gate_pkg.sv
package imp_gate_pkg;

  localparam int FLAG_W = 6;

  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_ACCEPT = 2'd1,
    VERD_RETRY  = 2'd2,
    VERD_REJECT = 2'd3
  } verdict_e;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_CONTACT = 3'd1,
    RSN_PHASE   = 3'd2,
    RSN_MAG     = 3'd3,
    RSN_SAT     = 3'd4,
    RSN_EXHAUST = 3'd5
  } reason_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_COLLECT,
    ST_DECIDE,
    ST_BACKOFF
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;        // clear group statistics and held faults
    logic acc;        // fold current burst into statistics
    logic capFault;   // latch status bits of a faulted burst
    logic publish;    // register quality flags
    logic pubAccept;  // register means
  } gate_strobe_t;

endpackage

// File: rtl/imp_gate_chan.sv
// Running min, max and sum of one channel over a burst group.
module imp_gate_chan #(
  parameter int DW     = 16,
  parameter int SUM_W  = 19,
  parameter int NSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              acc,
  input  logic [DW-1:0]     sample,
  input  logic [DW-1:0]     tol,
  input  logic [NSEL_W-1:0] shamt,
  output logic              spreadBad,
  output logic [DW-1:0]     mean
);

  logic [DW-1:0]    lo, hi, spread;
  logic [SUM_W-1:0] sum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lo  <= '1;
      hi  <= '0;
      sum <= '0;
    end else if (clr) begin
      lo  <= '1;
      hi  <= '0;
      sum <= '0;
    end else if (acc) begin
      if (sample < lo) lo <= sample;
      if (sample > hi) hi <= sample;
      sum <= sum + SUM_W'(sample);
    end
  end

  assign spread    = hi - lo;
  assign spreadBad = spread > tol;
  assign mean      = DW'(sum >> shamt);

endmodule

// File: rtl/imp_gate_dp.sv
module imp_gate_dp import imp_gate_pkg::*; #(
  parameter int DW     = 16,
  parameter int NSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strobe_t      stb,
  input  logic [DW-1:0]     burstMag,
  input  logic [DW-1:0]     burstPhase,
  input  logic              elecOpen,
  input  logic              contactFault,
  input  logic              adcSat,
  input  logic [DW-1:0]     cfgMagMax,
  input  logic [DW-1:0]     cfgMagTol,
  input  logic [DW-1:0]     cfgPhaseTol,
  input  logic [NSEL_W-1:0] cfgLog2N,
  output logic              curContact,
  output logic              curSat,
  output logic              heldContact,
  output logic              heldSat,
  output logic              phaseBad,
  output logic              magBad,
  output logic [DW-1:0]     magOut,
  output logic [DW-1:0]     phaseOut,
  output logic [FLAG_W-1:0] qualFlags
);

  localparam int SUM_W  = DW + (1 << NSEL_W) - 1;
  localparam int NCHAN  = 2;   // 0 magnitude, 1 phase

  logic [DW-1:0] chSample [NCHAN];
  logic [DW-1:0] chTol    [NCHAN];
  logic [DW-1:0] chMean   [NCHAN];
  logic          chBad    [NCHAN];

  assign chSample[0] = burstMag;
  assign chSample[1] = burstPhase;
  assign chTol[0]    = cfgMagTol;
  assign chTol[1]    = cfgPhaseTol;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    imp_gate_chan #(.DW(DW), .SUM_W(SUM_W), .NSEL_W(NSEL_W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (stb.clr),
      .acc      (stb.acc),
      .sample   (chSample[c]),
      .tol      (chTol[c]),
      .shamt    (cfgLog2N),
      .spreadBad(chBad[c]),
      .mean     (chMean[c])
    );
  end

  logic curRange;
  logic hOpen, hContact, hSat, hRange, heldAny;

  assign curRange   = burstMag > cfgMagMax;
  assign curContact = elecOpen | contactFault;
  assign curSat     = adcSat | curRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {hOpen, hContact, hSat, hRange} <= '0;
    end else if (stb.clr) begin
      {hOpen, hContact, hSat, hRange} <= '0;
    end else if (stb.capFault) begin
      hOpen    <= elecOpen;
      hContact <= contactFault;
      hSat     <= adcSat;
      hRange   <= curRange;
    end
  end

  assign heldAny     = hOpen | hContact | hSat | hRange;
  assign heldContact = hOpen | hContact;
  assign heldSat     = hSat | hRange;
  assign magBad      = !heldAny && chBad[0];
  assign phaseBad    = !heldAny && chBad[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magOut    <= '0;
      phaseOut  <= '0;
      qualFlags <= '0;
    end else begin
      if (stb.publish)
        qualFlags <= {magBad, phaseBad, hRange, hSat, hContact, hOpen};
      if (stb.pubAccept) begin
        magOut   <= chMean[0];
        phaseOut <= chMean[1];
      end
    end
  end

endmodule

// File: rtl/imp_gate_ctrl.sv
module imp_gate_ctrl import imp_gate_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int NSEL_W  = 2,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               burstValid,
  input  logic [CNT_W-1:0]   cfgSettle,
  input  logic [CNT_W-1:0]   cfgBackoff,
  input  logic [NSEL_W-1:0]  cfgLog2N,
  input  logic [RETRY_W-1:0] cfgMaxRetry,
  input  logic               curContact,
  input  logic               curSat,
  input  logic               heldContact,
  input  logic               heldSat,
  input  logic               phaseBad,
  input  logic               magBad,
  output gate_strobe_t       stb,
  output logic               measReq,
  output logic               verdictValid,
  output logic [1:0]         verdict,
  output logic [2:0]         reasonCode,
  output logic [RETRY_W-1:0] retryCnt
);

  localparam int MAXN   = 1 << ((1 << NSEL_W) - 1);
  localparam int NCNT_W = $clog2(MAXN + 1);

  state_e             state, nxt;
  logic [CNT_W-1:0]   timer;
  logic [NCNT_W-1:0]  burstCnt, groupN;
  reason_e            cause, reasonNow;
  verdict_e           verdNow;

  assign groupN  = NCNT_W'(1) << cfgLog2N;
  assign measReq = (state == ST_SETTLE) || (state == ST_COLLECT);

  always_comb begin
    cause = RSN_NONE;
    if (heldContact)   cause = RSN_CONTACT;
    else if (heldSat)  cause = RSN_SAT;
    else if (phaseBad) cause = RSN_PHASE;
    else if (magBad)   cause = RSN_MAG;
    if (cause == RSN_NONE)            verdNow = VERD_ACCEPT;
    else if (retryCnt == cfgMaxRetry) verdNow = VERD_REJECT;
    else                              verdNow = VERD_RETRY;
    reasonNow = (verdNow == VERD_REJECT) ? RSN_EXHAUST : cause;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        nxt     = ST_SETTLE;
        stb.clr = 1'b1;
      end
      ST_SETTLE: if (timer == '0) nxt = ST_COLLECT;
      ST_COLLECT: if (burstValid) begin
        if (curContact || curSat) begin
          stb.capFault = 1'b1;
          nxt          = ST_DECIDE;
        end else begin
          stb.acc = 1'b1;
          if (burstCnt + NCNT_W'(1) == groupN) nxt = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        stb.publish = 1'b1;
        if (verdNow == VERD_ACCEPT) begin
          stb.pubAccept = 1'b1;
          nxt           = ST_IDLE;
        end else if (verdNow == VERD_REJECT) begin
          nxt = ST_IDLE;
        end else begin
          nxt = ST_BACKOFF;
        end
      end
      ST_BACKOFF: if (timer == '0) begin
        nxt     = ST_SETTLE;
        stb.clr = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      timer        <= '0;
      burstCnt     <= '0;
      retryCnt     <= '0;
      verdictValid <= 1'b0;
      verdict      <= '0;
      reasonCode   <= '0;
    end else begin
      state <= nxt;
      if (nxt == ST_SETTLE && state != ST_SETTLE)
        timer <= cfgSettle;
      else if (nxt == ST_BACKOFF && state != ST_BACKOFF)
        timer <= cfgBackoff;
      else if (timer != '0)
        timer <= timer - CNT_W'(1);

      if (stb.clr)      burstCnt <= '0;
      else if (stb.acc) burstCnt <= burstCnt + NCNT_W'(1);

      if (state == ST_IDLE && start)
        retryCnt <= '0;
      else if (state == ST_DECIDE && verdNow == VERD_RETRY)
        retryCnt <= retryCnt + RETRY_W'(1);

      verdictValid <= (state == ST_DECIDE);
      if (state == ST_DECIDE) begin
        verdict    <= verdNow;
        reasonCode <= reasonNow;
      end
    end
  end

endmodule

// File: rtl/imp_quality_gate.sv
module imp_quality_gate import imp_gate_pkg::*; #(
  parameter int DW      = 16,
  parameter int CNT_W   = 16,
  parameter int NSEL_W  = 2,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   cfgSettle,
  input  logic [CNT_W-1:0]   cfgBackoff,
  input  logic [NSEL_W-1:0]  cfgLog2N,
  input  logic [RETRY_W-1:0] cfgMaxRetry,
  input  logic [DW-1:0]      cfgMagTol,
  input  logic [DW-1:0]      cfgPhaseTol,
  input  logic [DW-1:0]      cfgMagMax,
  input  logic               burstValid,
  input  logic [DW-1:0]      burstMag,
  input  logic [DW-1:0]      burstPhase,
  input  logic               elecOpen,
  input  logic               contactFault,
  input  logic               adcSat,
  output logic               measReq,
  output logic               verdictValid,
  output logic [1:0]         verdict,
  output logic [2:0]         reasonCode,
  output logic [RETRY_W-1:0] retryCnt,
  output logic [DW-1:0]      magOut,
  output logic [DW-1:0]      phaseOut,
  output logic [FLAG_W-1:0]  qualFlags
);

  gate_strobe_t stb;
  logic curContact, curSat, heldContact, heldSat, phaseBad, magBad;

  imp_gate_ctrl #(.CNT_W(CNT_W), .NSEL_W(NSEL_W), .RETRY_W(RETRY_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .burstValid  (burstValid),
    .cfgSettle   (cfgSettle),
    .cfgBackoff  (cfgBackoff),
    .cfgLog2N    (cfgLog2N),
    .cfgMaxRetry (cfgMaxRetry),
    .curContact  (curContact),
    .curSat      (curSat),
    .heldContact (heldContact),
    .heldSat     (heldSat),
    .phaseBad    (phaseBad),
    .magBad      (magBad),
    .stb         (stb),
    .measReq     (measReq),
    .verdictValid(verdictValid),
    .verdict     (verdict),
    .reasonCode  (reasonCode),
    .retryCnt    (retryCnt)
  );

  imp_gate_dp #(.DW(DW), .NSEL_W(NSEL_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .burstMag    (burstMag),
    .burstPhase  (burstPhase),
    .elecOpen    (elecOpen),
    .contactFault(contactFault),
    .adcSat      (adcSat),
    .cfgMagMax   (cfgMagMax),
    .cfgMagTol   (cfgMagTol),
    .cfgPhaseTol (cfgPhaseTol),
    .cfgLog2N    (cfgLog2N),
    .curContact  (curContact),
    .curSat      (curSat),
    .heldContact (heldContact),
    .heldSat     (heldSat),
    .phaseBad    (phaseBad),
    .magBad      (magBad),
    .magOut      (magOut),
    .phaseOut    (phaseOut),
    .qualFlags   (qualFlags)
  );

endmodule

// File: rtl/imp_gate_chk.sv
module imp_gate_chk import imp_gate_pkg::*; #(
  parameter int DW      = 16,
  parameter int RETRY_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [RETRY_W-1:0] cfgMaxRetry,
  input logic               measReq,
  input logic               verdictValid,
  input logic [1:0]         verdict,
  input logic [2:0]         reasonCode,
  input logic [RETRY_W-1:0] retryCnt,
  input logic [DW-1:0]      magOut,
  input logic [DW-1:0]      phaseOut,
  input logic [FLAG_W-1:0]  qualFlags
);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |=> !verdictValid);

  p_clean_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid && verdict == VERD_ACCEPT |-> reasonCode == RSN_NONE && qualFlags == '0);

  p_contact_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid && (qualFlags[1:0] != 2'b00) |-> verdict != VERD_ACCEPT);

  p_hold_values_r4: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid && verdict != VERD_ACCEPT |-> $stable(magOut) && $stable(phaseOut));

  p_phase_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid && qualFlags[4] |-> verdict != VERD_ACCEPT);

  p_retry_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid && verdict == VERD_RETRY |-> retryCnt == $past(retryCnt) + RETRY_W'(1) && !measReq);

  p_exhaust_r9: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid && verdict == VERD_REJECT |-> reasonCode == RSN_EXHAUST && retryCnt == cfgMaxRetry && !measReq);

endmodule

bind imp_quality_gate imp_gate_chk #(.DW(DW), .RETRY_W(RETRY_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgMaxRetry (cfgMaxRetry),
  .measReq     (measReq),
  .verdictValid(verdictValid),
  .verdict     (verdict),
  .reasonCode  (reasonCode),
  .retryCnt    (retryCnt),
  .magOut      (magOut),
  .phaseOut    (phaseOut),
  .qualFlags   (qualFlags)
);

// File: tb/sim_imp_quality_gate.sv
`timescale 1ns/1ps
module sim_imp_quality_gate;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] cfgSettle = 16'd5, cfgBackoff = 16'd7;
  logic [1:0]  cfgLog2N = 2'd2;
  logic [3:0]  cfgMaxRetry = 4'd2;
  logic [15:0] cfgMagTol = 16'd20, cfgPhaseTol = 16'd10, cfgMagMax = 16'd60000;
  logic burstValid = 1'b0;
  logic [15:0] burstMag = '0, burstPhase = '0;
  logic elecOpen = 1'b0, contactFault = 1'b0, adcSat = 1'b0;
  logic measReq, verdictValid;
  logic [1:0] verdict;
  logic [2:0] reasonCode;
  logic [3:0] retryCnt;
  logic [15:0] magOut, phaseOut;
  logic [5:0] qualFlags;

  always #10 clk = ~clk;

  imp_quality_gate u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgSettle(cfgSettle), .cfgBackoff(cfgBackoff), .cfgLog2N(cfgLog2N),
    .cfgMaxRetry(cfgMaxRetry), .cfgMagTol(cfgMagTol), .cfgPhaseTol(cfgPhaseTol),
    .cfgMagMax(cfgMagMax), .burstValid(burstValid), .burstMag(burstMag),
    .burstPhase(burstPhase), .elecOpen(elecOpen), .contactFault(contactFault),
    .adcSat(adcSat), .measReq(measReq), .verdictValid(verdictValid),
    .verdict(verdict), .reasonCode(reasonCode), .retryCnt(retryCnt),
    .magOut(magOut), .phaseOut(phaseOut), .qualFlags(qualFlags)
  );

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ms = 0, mc = 0;
  int mq[$];
  int pq[$];
  bit fOpen = 0, fCont = 0, fSat = 0, fRange = 0;
  int eVV = 0, eV = 0, eR = 0, eRetry = 0, eMag = 0, ePh = 0, eFl = 0;
  int mlo, mhi, plo, phi, msum, psum, cause;
  bit mBad, pBad, anyF;

  always @(posedge clk) begin
    if (!rstN) begin
      ms = 0; mc = 0; mq.delete(); pq.delete();
      {fOpen, fCont, fSat, fRange} = '0;
      eVV = 0; eV = 0; eR = 0; eRetry = 0; eMag = 0; ePh = 0; eFl = 0;
    end else begin
      eVV = 0;
      case (ms)
        0: if (start) begin ms = 1; mc = cfgSettle; eRetry = 0; end
        1: if (mc == 0) ms = 2; else mc--;
        2: if (burstValid) begin
          if (elecOpen || contactFault || adcSat || burstMag > cfgMagMax) begin
            fOpen = elecOpen; fCont = contactFault; fSat = adcSat;
            fRange = burstMag > cfgMagMax;
            ms = 3;
          end else begin
            mq.push_back(int'(burstMag));
            pq.push_back(int'(burstPhase));
            if (mq.size() == (1 << cfgLog2N)) ms = 3;
          end
        end
        3: begin
          mlo = 65535; mhi = 0; plo = 65535; phi = 0; msum = 0; psum = 0;
          foreach (mq[i]) begin
            if (mq[i] < mlo) mlo = mq[i];
            if (mq[i] > mhi) mhi = mq[i];
            if (pq[i] < plo) plo = pq[i];
            if (pq[i] > phi) phi = pq[i];
            msum += mq[i]; psum += pq[i];
          end
          anyF = fOpen | fCont | fSat | fRange;
          mBad = !anyF && (mhi - mlo > int'(cfgMagTol));
          pBad = !anyF && (phi - plo > int'(cfgPhaseTol));
          if (fOpen || fCont) cause = 1;
          else if (fSat || fRange) cause = 4;
          else if (pBad) cause = 2;
          else if (mBad) cause = 3;
          else cause = 0;
          eFl = (int'(mBad) << 5) | (int'(pBad) << 4) | (int'(fRange) << 3) |
                (int'(fSat) << 2) | (int'(fCont) << 1) | int'(fOpen);
          if (cause == 0) begin
            eV = 1; eR = 0; ms = 0;
            eMag = (msum >> cfgLog2N) & 16'hffff;
            ePh  = (psum >> cfgLog2N) & 16'hffff;
          end else if (eRetry == int'(cfgMaxRetry)) begin
            eV = 3; eR = 5; ms = 0;
          end else begin
            eV = 2; eR = cause; eRetry++; ms = 4; mc = cfgBackoff;
          end
          eVV = 1;
          mq.delete(); pq.delete();
          {fOpen, fCont, fSat, fRange} = '0;
        end
        4: if (mc == 0) begin ms = 1; mc = cfgSettle; end else mc--;
        default: ms = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(int'(measReq) == int'(ms == 1 || ms == 2), "MODEL measReq", int'(measReq), int'(ms == 1 || ms == 2));
      chk(int'(verdictValid) == eVV, "MODEL verdictValid", int'(verdictValid), eVV);
      chk(int'(verdict) == eV, "MODEL verdict", int'(verdict), eV);
      chk(int'(reasonCode) == eR, "MODEL reasonCode", int'(reasonCode), eR);
      chk(int'(retryCnt) == eRetry, "MODEL retryCnt", int'(retryCnt), eRetry);
      chk(int'(magOut) == eMag, "MODEL magOut", int'(magOut), eMag);
      chk(int'(phaseOut) == ePh, "MODEL phaseOut", int'(phaseOut), ePh);
      chk(int'(qualFlags) == eFl, "MODEL qualFlags", int'(qualFlags), eFl);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic startRun();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic burst(input int m, input int p, input bit op, input bit ct, input bit sat);
    @(negedge clk);
    burstValid = 1'b1; burstMag = 16'(m); burstPhase = 16'(p);
    elecOpen = op; contactFault = ct; adcSat = sat;
    @(negedge clk);
    burstValid = 1'b0; elecOpen = 1'b0; contactFault = 1'b0; adcSat = 1'b0;
  endtask

  task automatic expectVerdict(input string tag, input int v, input int r, input int fl,
                               input int rc, input int mg, input int ph);
    bit found = 1'b0;
    for (int i = 0; i < 2000 && !found; i++) begin
      @(negedge clk);
      if (verdictValid) found = 1'b1;
    end
    chk(found, {tag, " verdict strobe"}, int'(found), 1);
    chk(int'(verdict) == v, {tag, " verdict"}, int'(verdict), v);
    chk(int'(reasonCode) == r, {tag, " reason"}, int'(reasonCode), r);
    chk(int'(qualFlags) == fl, {tag, " flags"}, int'(qualFlags), fl);
    chk(int'(retryCnt) == rc, {tag, " retryCnt"}, int'(retryCnt), rc);
    chk(int'(magOut) == mg, {tag, " magOut"}, int'(magOut), mg);
    chk(int'(phaseOut) == ph, {tag, " phaseOut"}, int'(phaseOut), ph);
  endtask

  task automatic waitRearm();
    repeat (int'(cfgBackoff) + int'(cfgSettle) + 3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(measReq == 1'b0 && verdictValid == 1'b0, "R1 idle strobes", int'(measReq), 0);
    chk(magOut == '0 && phaseOut == '0, "R1 outputs zero", int'(magOut), 0);
    chk(qualFlags == '0 && retryCnt == '0 && verdict == '0, "R1 flags zero", int'(qualFlags), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(measReq == 1'b0 && reasonCode == '0, "R1 after release", int'(measReq), 0);

    // R2 + R3 + R11: faulted burst in settle ignored, spreads equal to tolerance
    startRun();
    chk(measReq == 1'b1, "R2 measReq raised", int'(measReq), 1);
    burst(5, 5, 1, 0, 0);
    repeat (int'(cfgSettle) + 2) @(negedge clk);
    burst(1000, 500, 0, 0, 0);
    burst(1010, 505, 0, 0, 0);
    burst(1020, 510, 0, 0, 0);
    burst(1006, 501, 0, 0, 0);
    expectVerdict("R3/R2/R11 accept", 1, 0, 0, 0, 1009, 504);

    // R5: phase spread 11 > 10 with flat magnitude
    startRun();
    repeat (int'(cfgSettle) + 3) @(negedge clk);
    burst(2000, 100, 0, 0, 0);
    burst(2000, 100, 0, 0, 0);
    burst(2000, 111, 0, 0, 0);
    burst(2000, 100, 0, 0, 0);
    expectVerdict("R5 phase spread", 2, 2, 6'h10, 1, 1009, 504);
    // R8: backoff keeps measurement request low for cfgBackoff+1 cycles
    chk(measReq == 1'b0, "R8 backoff start", int'(measReq), 0);
    repeat (int'(cfgBackoff)) @(negedge clk);
    chk(measReq == 1'b0, "R8 backoff end", int'(measReq), 0);
    @(negedge clk);
    chk(measReq == 1'b1, "R8 resettle", int'(measReq), 1);
    repeat (int'(cfgSettle) + 2) @(negedge clk);
    // R6: magnitude spread 21 > 20
    burst(2000, 300, 0, 0, 0);
    burst(2021, 300, 0, 0, 0);
    burst(2000, 300, 0, 0, 0);
    burst(2000, 300, 0, 0, 0);
    expectVerdict("R6 mag spread", 2, 3, 6'h20, 2, 1009, 504);
    waitRearm();
    // R9: retry budget spent, contact failure gives exhausted reject
    burst(2000, 300, 0, 1, 0);
    expectVerdict("R9 exhausted", 3, 5, 6'h02, 2, 1009, 504);

    // R4 + R7
    startRun();
    repeat (int'(cfgSettle) + 3) @(negedge clk);
    burst(1500, 400, 0, 0, 0);
    burst(1500, 400, 1, 0, 0);
    expectVerdict("R4 electrode open", 2, 1, 6'h01, 1, 1009, 504);
    waitRearm();
    burst(1500, 400, 0, 0, 1);
    expectVerdict("R7 saturation", 2, 4, 6'h04, 2, 1009, 504);
    waitRearm();
    burst(60001, 400, 0, 0, 0);
    expectVerdict("R7/R9 out of range", 3, 5, 6'h08, 2, 1009, 504);

    // R10: idle burst ignored, start while busy ignored, single-cycle strobe
    burst(10, 10, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(verdictValid == 1'b0 && measReq == 1'b0, "R10 idle burst ignored", int'(verdictValid), 0);
    chk(int'(verdict) == 3, "R10 verdict held", int'(verdict), 3);
    @(negedge clk) cfgLog2N = 2'd0;
    startRun();
    startRun();
    repeat (int'(cfgSettle) + 3) @(negedge clk);
    burst(777, 333, 0, 0, 0);
    expectVerdict("R10/R3 single burst", 1, 0, 0, 0, 777, 333);
    @(negedge clk);
    chk(verdictValid == 1'b0, "R10 strobe one cycle", int'(verdictValid), 0);
    repeat (3) @(negedge clk);
    chk(measReq == 1'b0, "R10 extra start ignored", int'(measReq), 0);

    // R6: both spreads fail, phase reason wins
    @(negedge clk) cfgLog2N = 2'd1;
    startRun();
    repeat (int'(cfgSettle) + 3) @(negedge clk);
    burst(100, 100, 0, 0, 0);
    burst(200, 200, 0, 0, 0);
    expectVerdict("R6 priority", 2, 2, 6'h30, 1, 777, 333);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule